// File: doc/BRIEF.md
# Audio DMA Interrupt Status Controller

This block gathers six event pulses from an audio DMA engine into one interrupt line. Each pulse lasts one cycle. Before an event can be recorded it must pass a source gate, the DMA mask register. An event that passes the gate sets a sticky bit in the status register. A second register, the mute register, decides which of those sticky bits can drive the interrupt. The interrupt line is a registered level. It stays high while any status bit is set and unmuted.

Software uses a byte-wide register port made of an address, a write enable, write data and combinational read data. To clear status bits it writes ones to them. Writing back the value it has just read clears exactly the bits it has handled. This port is a control path and has no back-pressure: every write is taken in the cycle it is presented, and read data follows the address in the same cycle. The event inputs are plain pulses with no handshake, because the block can always record an event.

Top module: `aud_dma_irq_ctrl`

## Requirements
- R1: After reset, status reads 0x00, mute reads 0x3F (all sources muted), the DMA mask reads 0xFF (all events blocked) and the interrupt is low.
- R2: An enabled event pulse sets its status bit at the next clock edge. The bit stays set for any number of cycles until software clears it.
- R3: An event whose source is blocked by the DMA mask leaves its status bit unchanged.
- R4: A write to the status register at byte address 0x109 clears exactly the bits written as one. Bits written as zero keep their value.
- R5: When an enabled event and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R6: The interrupt output goes high one clock edge after the status register holds a set bit whose mute bit is zero. It goes low one edge after no such bit remains.
- R7: The mute register sits at byte address 0x189 and stores bits 5..0. A mute bit of one keeps that source's status bit from driving the interrupt but does not stop the bit being recorded. Bits 7..6 read as zero.
- R8: The DMA mask register sits at byte address 0x3614 and stores all 8 bits. A zero at bit 7 enables done. A zero at bit 6 enables error, at bit 5 lost, at bit 4 retry, at bit 1 buffer full and at bit 0 buffer empty. Bits 3..2 are stored but gate nothing. Writing 0x7F enables done alone.
- R9: A read from any address other than the three registers returns 0x00.
- R10: Status and mute share one bit map: bit 5 error, bit 4 lost, bit 3 retry, bit 2 done, bit 1 buffer full, bit 0 buffer empty. Event input bit n maps to status bit n. Status bits 7..6 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | 16 | Byte address of the register access |
| reg_wr | input | 1 | Write strobe; the write takes effect at the next clock edge |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| evt_pulse | input | 6 | Event pulses, one cycle each, using the status bit map |
| irq | output | 1 | Registered level interrupt |

## Verification
A write or an event presented before a clock edge shows up in the register read data just after that edge, because reads are combinational from the registers. The interrupt comes one edge later, because it is registered from the status and mute values. The bench drives every stimulus for exactly one cycle. It then sets the read address and lets one more rising edge pass before it samples on the falling edge. At that point the read data and the interrupt are both settled for the step just applied. Asynchronous reset is checked on the falling edge right after it is asserted, with no clock edge needed.

// File: rtl/aud_irq_pkg.sv
package aud_irq_pkg;
  localparam int unsigned NUM_EVT = 6;
  localparam int unsigned DATA_W  = 8;

  // status / mute bit positions
  localparam int unsigned EV_EMPTY = 0;
  localparam int unsigned EV_FULL  = 1;
  localparam int unsigned EV_DONE  = 2;
  localparam int unsigned EV_RETRY = 3;
  localparam int unsigned EV_LOST  = 4;
  localparam int unsigned EV_ERROR = 5;

  // DMA mask bit that gates each status bit, indexed by status bit
  function automatic int unsigned mask_pos(input int unsigned ev);
    case (ev)
      EV_EMPTY: mask_pos = 0;
      EV_FULL:  mask_pos = 1;
      EV_DONE:  mask_pos = 7;
      EV_RETRY: mask_pos = 4;
      EV_LOST:  mask_pos = 5;
      default:  mask_pos = 6;
    endcase
  endfunction

  localparam logic [NUM_EVT-1:0] MUTE_RST = '1;
  localparam logic [DATA_W-1:0]  MASK_RST = '1;
endpackage

// File: rtl/aud_irq_regs.sv
module aud_irq_regs
  import aud_irq_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter logic [15:0] OFS_STATUS = 16'h0109,
  parameter logic [15:0] OFS_MUTE   = 16'h0189,
  parameter logic [15:0] OFS_MASK   = 16'h3614
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               wr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic [NUM_EVT-1:0] status_i,
  output logic [NUM_EVT-1:0] mute_o,
  output logic [NUM_EVT-1:0] evt_en_o,
  output logic [NUM_EVT-1:0] clr_o,
  output logic [DATA_W-1:0]  rdata_o
);
  localparam int unsigned PAD_W = DATA_W - NUM_EVT;

  logic              sel_status, sel_mute, sel_mask;
  logic [NUM_EVT-1:0] mute_q;
  logic [DATA_W-1:0]  mask_q;

  assign sel_status = (addr_i == ADDR_W'(OFS_STATUS));
  assign sel_mute   = (addr_i == ADDR_W'(OFS_MUTE));
  assign sel_mask   = (addr_i == ADDR_W'(OFS_MASK));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mute_q <= MUTE_RST;
      mask_q <= MASK_RST;
    end else if (wr_i) begin
      if (sel_mute) mute_q <= wdata_i[NUM_EVT-1:0];
      if (sel_mask) mask_q <= wdata_i;
    end
  end

  assign clr_o  = (wr_i && sel_status) ? wdata_i[NUM_EVT-1:0] : '0;
  assign mute_o = mute_q;

  for (genvar g = 0; g < NUM_EVT; g++) begin : g_gate
    assign evt_en_o[g] = ~mask_q[mask_pos(g)];
  end

  always_comb begin
    rdata_o = '0;
    if (sel_status)    rdata_o = {{PAD_W{1'b0}}, status_i};
    else if (sel_mute) rdata_o = {{PAD_W{1'b0}}, mute_q};
    else if (sel_mask) rdata_o = mask_q;
  end

  always_comb begin
    if (!(sel_status || sel_mute || sel_mask))
      p_unmapped_zero_r9: assert (rdata_o == '0);
  end
endmodule

// File: rtl/aud_irq_capture.sv
module aud_irq_capture
  import aud_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic [NUM_EVT-1:0] evt_en_i,
  input  logic [NUM_EVT-1:0] clr_i,
  output logic [NUM_EVT-1:0] status_o
);
  logic [NUM_EVT-1:0] status_q;

  for (genvar g = 0; g < NUM_EVT; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     status_q[g] <= 1'b0;
      else if (evt_i[g] && evt_en_i[g]) status_q[g] <= 1'b1;
      else if (clr_i[g])              status_q[g] <= 1'b0;
    end
  end

  assign status_o = status_q;

  // R2 and R5: every gated event shows up set one edge later, clear or not
  p_event_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((($past(evt_i & evt_en_i)) & ~status_q) == '0));

  // R3: a bit may only rise if its event was enabled
  p_masked_no_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (((~$past(status_q)) & status_q & ~$past(evt_i & evt_en_i)) == '0));

  // R4: a bit may only fall under a clearing write
  p_clear_only_w1c_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(status_q) & ~status_q & ~$past(clr_i)) == '0));
endmodule

// File: rtl/aud_irq_line.sv
module aud_irq_line
  import aud_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] status_i,
  input  logic [NUM_EVT-1:0] mute_i,
  output logic               irq_o
);
  logic irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |(status_i & ~mute_i);
  end

  assign irq_o = irq_q;

  // R6: level follows unmuted status with one edge of delay
  p_irq_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o == $past(|(status_i & ~mute_i))));

  // R7: fully muted status never raises the line
  p_mute_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mute_i) == '1) |-> !irq_o);
endmodule

// File: rtl/aud_dma_irq_ctrl.sv
module aud_dma_irq_ctrl
  import aud_irq_pkg::*;
#(
  parameter int unsigned ADDR_W     = 16,
  parameter logic [15:0] OFS_STATUS = 16'h0109,
  parameter logic [15:0] OFS_MUTE   = 16'h0189,
  parameter logic [15:0] OFS_MASK   = 16'h3614
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic [5:0]        evt_pulse,
  output logic              irq
);
  logic [NUM_EVT-1:0] status, mute, evt_en, clr;

  aud_irq_regs #(
    .ADDR_W(ADDR_W), .OFS_STATUS(OFS_STATUS),
    .OFS_MUTE(OFS_MUTE), .OFS_MASK(OFS_MASK)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .addr_i(reg_addr), .wr_i(reg_wr),
    .wdata_i(reg_wdata), .status_i(status), .mute_o(mute),
    .evt_en_o(evt_en), .clr_o(clr), .rdata_o(reg_rdata)
  );

  aud_irq_capture u_cap (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_pulse), .evt_en_i(evt_en),
    .clr_i(clr), .status_o(status)
  );

  aud_irq_line u_line (
    .clk(clk), .rst_n(rst_n), .status_i(status), .mute_i(mute),
    .irq_o(irq)
  );
endmodule

// File: tb/tb_aud_dma_irq_ctrl.sv
module tb_aud_dma_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic [5:0]  evt_pulse = '0;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  aud_dma_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_pulse(evt_pulse),
    .irq(irq)
  );

  localparam logic [1:0] OP_WR = 2'd0, OP_EV = 2'd1, OP_RD = 2'd2;
  localparam logic [15:0] A_ST = 16'h0109, A_MU = 16'h0189, A_MK = 16'h3614;

  typedef struct packed {
    logic [1:0]  op;
    logic [15:0] addr;
    logic [7:0]  data;
    logic        irq;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 41;
  localparam vec_t VEC [NV] = '{
    '{OP_RD, A_MU, 8'h3F, 1'b0, 4'd1},  // R1 mute reset
    '{OP_RD, A_MK, 8'hFF, 1'b0, 4'd1},  // R1 mask reset
    '{OP_RD, A_ST, 8'h00, 1'b0, 4'd1},  // R1 status reset
    '{OP_EV, 16'h0, 8'h3F, 1'b0, 4'd3},
    '{OP_RD, A_ST, 8'h00, 1'b0, 4'd3},  // R3 all blocked
    '{OP_WR, A_MK, 8'h7F, 1'b0, 4'd8},
    '{OP_EV, 16'h0, 8'h3F, 1'b0, 4'd8},
    '{OP_RD, A_ST, 8'h04, 1'b0, 4'd8},  // R8 done only; R7 muted
    '{OP_WR, A_MU, 8'h3B, 1'b0, 4'd7},
    '{OP_RD, A_ST, 8'h04, 1'b1, 4'd6},  // R6 unmuted done raises irq
    '{OP_WR, A_MK, 8'h00, 1'b0, 4'd8},
    '{OP_EV, 16'h0, 8'h21, 1'b0, 4'd10},
    '{OP_RD, A_ST, 8'h25, 1'b1, 4'd10}, // R10 error and empty bits
    '{OP_WR, A_ST, 8'h04, 1'b0, 4'd4},
    '{OP_RD, A_ST, 8'h21, 1'b0, 4'd4},  // R4 only done cleared, irq drops
    '{OP_WR, A_MU, 8'h1F, 1'b0, 4'd7},
    '{OP_RD, A_ST, 8'h21, 1'b1, 4'd7},  // R7 unmuted error drives irq
    '{OP_RD, 16'h0001, 8'h00, 1'b1, 4'd9}, // R9 unmapped
    '{OP_RD, 16'h3615, 8'h00, 1'b1, 4'd9}, // R9 unmapped neighbour
    '{OP_WR, A_ST, 8'h3F, 1'b0, 4'd4},
    '{OP_RD, A_ST, 8'h00, 1'b0, 4'd4},  // R4 clear all
    '{OP_WR, A_MU, 8'hFF, 1'b0, 4'd7},
    '{OP_RD, A_MU, 8'h3F, 1'b0, 4'd7},  // R7 upper bits dropped
    '{OP_WR, A_MK, 8'hBF, 1'b0, 4'd8},
    '{OP_EV, 16'h0, 8'h3F, 1'b0, 4'd8},
    '{OP_RD, A_ST, 8'h20, 1'b0, 4'd8},  // R8 bit 6 gates error
    '{OP_WR, A_ST, 8'h20, 1'b0, 4'd4},
    '{OP_WR, A_MK, 8'hDF, 1'b0, 4'd8},
    '{OP_EV, 16'h0, 8'h3F, 1'b0, 4'd8},
    '{OP_RD, A_ST, 8'h10, 1'b0, 4'd8},  // R8 bit 5 gates lost
    '{OP_WR, A_ST, 8'h10, 1'b0, 4'd4},
    '{OP_WR, A_MK, 8'hEF, 1'b0, 4'd8},
    '{OP_EV, 16'h0, 8'h3F, 1'b0, 4'd8},
    '{OP_RD, A_ST, 8'h08, 1'b0, 4'd8},  // R8 bit 4 gates retry
    '{OP_WR, A_ST, 8'h08, 1'b0, 4'd4},
    '{OP_WR, A_MK, 8'hF0, 1'b0, 4'd8},
    '{OP_EV, 16'h0, 8'h04, 1'b0, 4'd8},
    '{OP_RD, A_ST, 8'h00, 1'b0, 4'd8},  // R8 bits 3..2 gate nothing
    '{OP_WR, A_MK, 8'hFD, 1'b0, 4'd8},
    '{OP_EV, 16'h0, 8'h3F, 1'b0, 4'd8},
    '{OP_RD, A_ST, 8'h02, 1'b0, 4'd8}   // R8 bit 1 gates full
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic ev(input logic [5:0] e);
    evt_pulse = e;
    @(negedge clk);
    evt_pulse = '0;
  endtask

  task automatic rd(input logic [15:0] a, input logic [7:0] exp, input logic ei, input string tag);
    reg_addr = a;
    @(negedge clk);
    chk({tag, " rdata"}, reg_rdata, exp);
    chk({tag, " irq"}, {7'd0, irq}, {7'd0, ei});
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      case (VEC[i].op)
        OP_WR: wr(VEC[i].addr, VEC[i].data);
        OP_EV: ev(VEC[i].data[5:0]);
        default: rd(VEC[i].addr, VEC[i].data, VEC[i].irq,
                    $sformatf("R%0d vec%0d", VEC[i].req, i));
      endcase
    end

    // R5: event and clear on the same bit in one cycle, set wins
    wr(A_ST, 8'h3F);
    wr(A_MK, 8'h00);
    wr(A_MU, 8'h00);
    reg_addr = A_ST; reg_wdata = 8'h05; reg_wr = 1'b1; evt_pulse = 6'h04;
    @(negedge clk);
    reg_wr = 1'b0; evt_pulse = '0;
    rd(A_ST, 8'h04, 1'b1, "R5 set beats clear");

    // R2: bit stays set across idle cycles
    repeat (20) @(negedge clk);
    rd(A_ST, 8'h04, 1'b1, "R2 sticky");

    // R6: clear drops irq one edge later; check before and after that edge
    reg_addr = A_ST; reg_wdata = 8'h04; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    chk("R6 irq still high before edge", {7'd0, irq}, 8'h01);
    @(negedge clk);
    chk("R6 irq low after edge", {7'd0, irq}, 8'h00);

    // R1: reset during operation restores defaults asynchronously
    ev(6'h3F);
    rd(A_ST, 8'h3F, 1'b1, "R2 all sources");
    #2 rst_n = 1'b0;
    #1;
    reg_addr = A_ST; #1 chk("R1 status after reset", reg_rdata, 8'h00);
    chk("R1 irq after reset", {7'd0, irq}, 8'h00);
    reg_addr = A_MU; #1 chk("R1 mute after reset", reg_rdata, 8'h3F);
    reg_addr = A_MK; #1 chk("R1 mask after reset", reg_rdata, 8'hFF);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule